// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Zero Turnaround

This block is a synchronous, flow-through static RAM whose bus can change between reads and writes on every clock with no idle cycle between them. Commands, addresses, byte masks and write data are all captured on the rising clock edge. A read returns its data in the cycle right after the edge that sampled its address. A write takes its data on the next active edge after its address. Because each direction keeps to its own fixed latency, back-to-back mixed traffic never collides.

A load edge starts an access at an external address. Advance edges then step a 2-bit beat counter, which walks through the four words of the aligned group in either linear or interleaved order. An active-low clock enable freezes the whole block. Three chip selects gate new accesses, and a deselect ends a burst while still letting a write that is already pending finish. An asynchronous output enable can turn the data drive off at any moment. The array is small and set by parameters, and every byte lane is 9 bits wide.

Top module: `sram_ft_top`

## Requirements
- R1: While rst_ni is low and after it is released, no burst is active and dq_oe_o is low until the first read is loaded.
- R2: An edge with cen_ni high changes no state. No address, command, byte mask or data is taken and no write is performed. The outputs keep their values.
- R3: An active edge (cen_ni low) with ld_ni low and every chip select active (ce1_ni=0, ce2_i=1, ce3_ni=0) starts a new access at addr_i. It is a write when we_ni=0 and a read when we_ni=1.
- R4: For a read beat sampled at an active edge, the word at that beat's address is on dq_o with dq_oe_o high (oe_ni low) from just after that edge until the next active edge.
- R5: The data of a write beat is taken from dq_i at the next active edge after the beat was sampled. Byte lane b is bits [9b+8:9b], and it is written only if bwe_ni[b] was 0 at the beat's sampling edge.
- R6: An active edge with ld_ni high during a burst advances the beat count by one, modulo 4. With ord_i=0 (linear) the low two address bits are (start+count) mod 4. With ord_i=1 (interleaved) they are start XOR count. The upper address bits stay fixed.
- R7: An active edge with ld_ni low and any chip select inactive ends the burst. Later advance edges neither drive nor write. A write beat sampled at the previous edge still completes.
- R8: Reads and writes may alternate on consecutive active edges with no idle cycle. A read loaded at the edge that completes a write to the same address returns the new data.
- R9: oe_ni high forces dq_oe_o low at once, without a clock, and leaves the internal state alone.
- R10: dq_oe_o is low during write beats and after a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| ce1_ni | input | 1 | Chip select 1, active low |
| ce2_i | input | 1 | Chip select 2, active high |
| ce3_ni | input | 1 | Chip select 3, active low |
| ld_ni | input | 1 | Low: load new address; high: advance burst |
| we_ni | input | 1 | Write select at load, active low |
| bwe_ni | input | BYTES | Per-lane write selects, active low |
| addr_i | input | ADDR_W | Word address |
| ord_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | BYTES*9 | Write data |
| dq_o | output | BYTES*9 | Read data |
| dq_oe_o | output | 1 | Data drive enable |

## Verification
A read beat sampled at active edge N is due on dq_o in the half cycle that follows edge N. A write beat sampled at edge N only shows its effect after active edge N+1, or after a later edge when cen_ni stalls in between. The bench drives every input at the falling edge. After each rising edge it steps a behavioural model that applies the pending write before it decodes the new command. At the next falling edge it compares drive and data, so each result is checked exactly one edge after its cause. Frozen edges leave the model untouched, so any write or read that a stall wrongly releases shows up in the compare.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;
  localparam int LANE_W = 9;

  typedef enum logic {
    ORD_LIN = 1'b0,
    ORD_ILV = 1'b1
  } burst_ord_e;

  // low address bits of a beat from its start bits and count
  function automatic logic [1:0] beat_low(logic [1:0] start, logic [1:0] cnt, burst_ord_e ord);
    logic [1:0] res;
    if (ord == ORD_ILV) res = start ^ cnt;
    else                res = start + cnt;
    return res;
  endfunction
endpackage

// File: rtl/sram_ft_beat_addr.sv
module sram_ft_beat_addr
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        cnt_i,
  input  logic              ord_i,
  output logic [ADDR_W-1:0] addr_o
);
  burst_ord_e ord;
  assign ord = burst_ord_e'(ord_i);

  always_comb begin
    addr_o      = base_i;
    addr_o[1:0] = beat_low(base_i[1:0], cnt_i, ord);
  end
endmodule

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ld_ni,
  input  logic              sel_i,
  input  logic              we_ni,
  input  logic [BYTES-1:0]  bwe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ord_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_vld_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTES-1:0]  wr_mask_o
);
  logic              act_q, wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              act_d, wr_d;
  logic [ADDR_W-1:0] base_d;
  logic [1:0]        cnt_d;
  logic [ADDR_W-1:0] beat_addr;

  logic              wp_vld_q;
  logic [ADDR_W-1:0] wp_addr_q;
  logic [BYTES-1:0]  wp_mask_q;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (!ld_ni) begin
      if (sel_i) begin
        act_d  = 1'b1;
        wr_d   = !we_ni;
        base_d = addr_i;
        cnt_d  = 2'd0;
      end else begin
        act_d  = 1'b0;
      end
    end else if (act_q) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  // address of the beat being sampled at this edge
  sram_ft_beat_addr #(.ADDR_W(ADDR_W)) u_beat_nxt (
    .base_i (base_d),
    .cnt_i  (cnt_d),
    .ord_i  (ord_i),
    .addr_o (beat_addr)
  );

  // address of the beat now in flight
  sram_ft_beat_addr #(.ADDR_W(ADDR_W)) u_beat_cur (
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .ord_i  (ord_i),
    .addr_o (rd_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      wr_q      <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      wp_vld_q  <= 1'b0;
      wp_addr_q <= '0;
      wp_mask_q <= '0;
    end else if (!cen_ni) begin
      act_q     <= act_d;
      wr_q      <= wr_d;
      base_q    <= base_d;
      cnt_q     <= cnt_d;
      wp_vld_q  <= act_d && wr_d;
      wp_addr_q <= beat_addr;
      wp_mask_q <= ~bwe_ni;
    end
  end

  assign rd_vld_o  = act_q && !wr_q;
  assign wr_en_o   = wp_vld_q && !cen_ni;
  assign wr_addr_o = wp_addr_q;
  assign wr_mask_o = wp_mask_q;
endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                      clk_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [BYTES-1:0]          wr_mask_i,
  input  logic [BYTES*LANE_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [BYTES*LANE_W-1:0]   rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_mask_i[g]) mem_q[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = mem_q[rd_addr_i];
  end
endmodule

// File: rtl/sram_ft_top.sv
module sram_ft_top
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  localparam int DW    = BYTES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              ld_ni,
  input  logic              we_ni,
  input  logic [BYTES-1:0]  bwe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ord_i,
  input  logic              oe_ni,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o
);
  logic              ce_ok;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              rd_vld, wr_en;
  logic [BYTES-1:0]  wr_mask;

  assign ce_ok = !ce1_ni && ce2_i && !ce3_ni;

  sram_ft_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cen_ni    (cen_ni),
    .ld_ni     (ld_ni),
    .sel_i     (ce_ok),
    .we_ni     (we_ni),
    .bwe_ni    (bwe_ni),
    .addr_i    (addr_i),
    .ord_i     (ord_i),
    .rd_addr_o (rd_addr),
    .rd_vld_o  (rd_vld),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_mask_o (wr_mask)
  );

  sram_ft_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_mask_i (wr_mask),
    .wr_data_i (dq_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (dq_o)
  );

  assign dq_oe_o = rd_vld && !oe_ni;
endmodule

// File: rtl/sram_ft_chk.sv
module sram_ft_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              ld_ni,
  input logic              ce_ok,
  input logic              we_ni,
  input logic              ord_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_vld,
  input logic              wr_en,
  input logic              dq_oe_o
);
  assert_freeze_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> (ord_i != $past(ord_i)) || ($stable(rd_addr) && $stable(rd_vld)));

  assert_load_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && ce_ok) |=> rd_addr == $past(addr_i));

  assert_write_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && ce_ok && !we_ni) |=> (cen_ni || wr_en));

  assert_lin_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && ld_ni && rd_vld && !ord_i) |=>
      (ord_i != $past(ord_i)) || (rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1));

  assert_deselect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && !ce_ok) |=> !rd_vld && !dq_oe_o);

  assert_wr_no_drive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && ce_ok && !we_ni) |=> !dq_oe_o);
endmodule

bind sram_ft_top sram_ft_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cen_ni  (cen_ni),
  .ld_ni   (ld_ni),
  .ce_ok   (ce_ok),
  .we_ni   (we_ni),
  .ord_i   (ord_i),
  .addr_i  (addr_i),
  .rd_addr (rd_addr),
  .rd_vld  (rd_vld),
  .wr_en   (wr_en),
  .dq_oe_o (dq_oe_o)
);

// File: tb/sram_ft_top_tb.sv
module sram_ft_top_tb;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = NB * 9;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cen_ni = 1'b0, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic ld_ni = 1'b1, we_ni = 1'b1, ord_i = 1'b0, oe_ni = 1'b0;
  logic [NB-1:0] bwe_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o;

  always #10 clk_i = ~clk_i;

  sram_ft_top #(.ADDR_W(AW), .BYTES(NB)) u_dut (
    .clk_i, .rst_ni, .cen_ni, .ce1_ni, .ce2_i, .ce3_ni, .ld_ni, .we_ni,
    .bwe_ni, .addr_i, .ord_i, .oe_ni, .dq_i, .dq_o, .dq_oe_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] rm [DEPTH];
  logic [NB-1:0] lv [DEPTH];
  bit m_act = 0, m_wr = 0, m_wp = 0;
  int m_base = 0, m_cnt = 0, m_wpa = 0;
  logic [NB-1:0] m_wpm = '0;

  function automatic int beat(int base, int cnt, bit ord);
    int lo;
    lo = ord ? ((base & 3) ^ cnt) : (((base & 3) + cnt) % 4);
    return (base & ~3) | lo;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit drv;
    int a;
    drv = m_act && !m_wr && !oe_ni;
    chk(tag, DW'(dq_oe_o), DW'(drv));
    if (drv) begin
      a = beat(m_base, m_cnt, ord_i);
      for (int b = 0; b < NB; b++)
        if (lv[a][b]) chk(tag, DW'(dq_o[b*9 +: 9]), DW'(rm[a][b*9 +: 9]));
    end
  endtask

  // cs: 0 all selected, 1..3 that chip select inactive
  task automatic step(string tag, bit cen, bit ld, int cs, bit we, int addr,
                      logic [DW-1:0] din, logic [NB-1:0] bwe);
    bit sel;
    cen_ni = cen; ld_ni = ld; we_ni = we; addr_i = AW'(addr); dq_i = din; bwe_ni = bwe;
    ce1_ni = (cs == 1); ce2_i = (cs != 2); ce3_ni = (cs == 3);
    sel = (cs == 0);
    @(posedge clk_i);
    if (!cen) begin
      if (m_wp)
        for (int b = 0; b < NB; b++)
          if (m_wpm[b]) begin
            rm[m_wpa][b*9 +: 9] = din[b*9 +: 9];
            lv[m_wpa][b] = 1'b1;
          end
      if (!ld) begin
        if (sel) begin m_act = 1; m_wr = !we; m_base = addr; m_cnt = 0; end
        else m_act = 0;
      end else if (m_act) m_cnt = (m_cnt + 1) % 4;
      m_wp = m_act && m_wr;
      m_wpa = beat(m_base, m_cnt, ord_i);
      m_wpm = ~bwe;
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b1, 0, 1'b1, 0, '0, '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) lv[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset", DW'(dq_oe_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle("R1");
    chk("R1 idle", DW'(dq_oe_o), '0);

    // R3 R5 R6 linear write burst from start 2, then deselect finishing last beat (R7)
    step("R3", 0, 0, 0, 0, 'h0A, '0, 2'b00);
    step("R5", 0, 1, 0, 1, 0, 18'h11111, 2'b00);
    step("R5", 0, 1, 0, 1, 0, 18'h22222, 2'b00);
    step("R10", 0, 1, 0, 1, 0, 18'h33333, 2'b00);
    step("R7", 0, 0, 2, 1, 0, 18'h04444, 2'b00);
    step("R7", 0, 1, 0, 1, 0, 18'h3ffff, 2'b00);
    // R4 R6 linear read burst
    step("R4", 0, 0, 0, 1, 'h0A, '0, '1);
    for (int i = 0; i < 4; i++) step("R6", 0, 1, 0, 1, 0, '0, '1);

    // R6 interleaved write at start 1 then read starting at 3
    ord_i = 1'b1;
    step("R3", 0, 0, 0, 0, 'h11, '0, 2'b00);
    step("R6", 0, 1, 0, 1, 0, 18'h0a0a1, 2'b00);
    step("R6", 0, 1, 0, 1, 0, 18'h0b0b2, 2'b00);
    step("R6", 0, 1, 0, 1, 0, 18'h0c0c3, 2'b00);
    step("R6", 0, 0, 3, 1, 0, 18'h0d0d4, 2'b00);
    step("R6", 0, 0, 0, 1, 'h13, '0, '1);
    for (int i = 0; i < 4; i++) step("R6", 0, 1, 0, 1, 0, '0, '1);
    ord_i = 1'b0;

    // R5 byte mask: lane 1 disabled, lane 0 written
    step("R5", 0, 0, 0, 0, 'h0B, '0, 2'b10);
    step("R5", 0, 0, 0, 1, 'h0B, 18'h155aa, '1);
    step("R5", 0, 0, 0, 0, 'h0B, '0, 2'b01);
    step("R5", 0, 0, 0, 1, 'h0B, 18'h2a1ff, '1);

    // R8 alternate write and read of the same word each edge
    step("R8", 0, 0, 0, 0, 32, '0, 2'b00);
    for (int i = 0; i < 8; i++) begin
      step("R8", 0, 0, 0, 1, 32 + i, 18'(i * 4099 + 7), 2'b00);
      step("R8", 0, 0, 0, 0, 33 + i, '0, 2'b00);
    end
    step("R8", 0, 0, 1, 1, 0, 18'h12345, 2'b00);

    // R2 stalls inside a read burst and with a write pending
    step("R2", 0, 0, 0, 1, 'h20, '0, '1);
    step("R2", 1, 0, 0, 0, 'h3f, 18'h3dead, 2'b00);
    step("R2", 1, 1, 0, 0, 'h01, 18'h3beef, 2'b00);
    step("R2", 0, 1, 0, 1, 0, '0, '1);
    step("R2", 0, 0, 0, 0, 'h24, '0, 2'b00);
    step("R2", 1, 0, 0, 1, 'h00, 18'h1f00f, 2'b11);
    step("R2", 1, 1, 1, 1, 'h00, 18'h1f00f, 2'b11);
    step("R2", 0, 1, 0, 1, 0, 18'h2c3c3, 2'b11);
    step("R2", 0, 0, 1, 1, 0, 18'h3eeee, 2'b11);
    step("R2", 0, 0, 0, 1, 'h24, '0, '1);
    step("R2", 0, 1, 0, 1, 0, '0, '1);

    // R7 deselect in a read burst; advances afterwards do nothing
    step("R7", 0, 0, 0, 1, 'h08, '0, '1);
    step("R7", 0, 0, 3, 1, 0, '0, '1);
    step("R7", 0, 1, 0, 1, 0, 18'h0bad0, 2'b00);
    step("R7", 0, 1, 0, 0, 0, 18'h0bad1, 2'b00);
    step("R7", 0, 0, 0, 1, 'h08, '0, '1);

    // R9 asynchronous output enable
    step("R9", 0, 0, 0, 1, 'h0A, '0, '1);
    #2 oe_ni = 1'b1;
    #1 chk("R9 off", DW'(dq_oe_o), '0);
    #2 oe_ni = 1'b0;
    #1 chk("R9 on", DW'(dq_oe_o), DW'(1));
    @(negedge clk_i);
    step("R9", 0, 1, 0, 1, 0, '0, '1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule